// File: doc/BRIEF.md
# Glitch-Free PWM Generator with Locked Configuration Commit

This block produces a single left-aligned pulse-width-modulated output from a free-running counter. Software programs it through a small word-addressed register port that holds four words: the live count, the period, the duty and a control word. The control word carries the enable, the two polarity bits, the alignment and low-power selections, and a lock bit.

Every write to period, duty or control lands first in a shadow copy. The active configuration that drives the output is loaded only at a period boundary, and only while the lock bit is clear. Software can therefore set the lock while keeping the old polarity, write a new period and duty, and then clear the lock while writing the new polarity. All three then take effect together when the current period ends. The channel never needs to be switched off, and no mixed configuration ever reaches the pin.

A three-state commit machine tracks outstanding shadow changes. It has three states:
- `ST_IDLE`: nothing is pending.
- `ST_ARMED`: a change is pending and may commit.
- `ST_HELD`: a change is pending but locked.

Its transitions are:
- *stage*: `ST_IDLE` to `ST_ARMED` on any shadow write.
- *freeze*: `ST_ARMED` to `ST_HELD` while the lock is set.
- *release*: `ST_HELD` to `ST_ARMED` once the lock clears.
- *apply*: `ST_ARMED` to `ST_IDLE` at a boundary with the lock clear. If another shadow write arrives in that same cycle, the machine returns to `ST_ARMED` instead.

A boundary is the last count of a period, any cycle while the channel is disabled, or any cycle while the active period is 0.

Top module: `pwm_atomic`

## Requirements
- R1: After reset the output is low, and reads of all four words return 0.
- R2: While enabled with a nonzero active period P, the count runs 0,1,…,P-1 and wraps to 0. A read at word address 0x0 returns the live count. Writes to address 0x0 are ignored.
- R3: While control bit 6 (lock) is 1, writes to period (0x4), duty (0x8) and the polarity bits leave the running output unchanged. Reads of 0x4 and 0x8 return the newly written values.
- R4: After the lock is cleared, the pending period, duty and polarity all take effect at the start of the next period. The rest of the current period keeps the old configuration.
- R5: With the lock clear, a period or duty write made mid-period takes effect only at the next period boundary.
- R6: The output is at the active level while count < duty, and at the idle level otherwise. The active level is control bit 3 (1 = high). The idle level is control bit 4 (1 = high).
- R7: A duty of 0 gives a constant idle level. A duty ≥ period gives a constant active level. A period of 0 gives a constant idle level with the count held at 0.
- R8: With control bit 0 (enable) at 0, the output sits at the idle level and the count is held at 0.
- R9: Control reads return the stored bits 0, 3, 4, 5, 6 and 8 (mask 0x179); all other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 4 | Byte address: 0x0 count, 0x4 period, 0x8 duty, 0xC control |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for `addr` |
| pwm_out | output | 1 | Modulated output |

## Verification
A write is captured on the rising edge after the bench raises `wr_en`. A change staged with the lock clear is loaded at the first later edge on which the count sits at P-1. From that edge on, the output follows the new values with no extra delay, because it is decoded directly from registered state.

The bench drives and samples on falling edges. It finds the period phase by polling the live count, and writes when the count reads 1, so the write lands on the edge that moves the count to 3. The next seven samples therefore belong to the old configuration and the ten or twenty that follow belong to the new one. Duty checks count active samples over a whole number of periods, after a settling wait of more than one full period.

// File: rtl/pwm_atomic_pkg.sv
`timescale 1ns/1ps
package pwm_atomic_pkg;

    // Word select decoded from addr[3:2]
    typedef enum logic [1:0] {
        SEL_COUNT  = 2'd0,
        SEL_PERIOD = 2'd1,
        SEL_DUTY   = 2'd2,
        SEL_CTRL   = 2'd3
    } word_sel_e;

    // Commit machine states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_HELD  = 2'd2
    } commit_st_e;

    // Control word bit positions
    localparam int CB_ENABLE   = 0;
    localparam int CB_ACT_HIGH = 3;
    localparam int CB_IDLE_HI  = 4;
    localparam int CB_ALIGN    = 5;
    localparam int CB_LOCK     = 6;
    localparam int CB_LOWPWR   = 8;
    localparam int CTRL_BITS   = 9;

    localparam logic [CTRL_BITS-1:0] CTRL_KEEP =
        CTRL_BITS'((1 << CB_ENABLE) | (1 << CB_ACT_HIGH) | (1 << CB_IDLE_HI) |
                   (1 << CB_ALIGN)  | (1 << CB_LOCK)     | (1 << CB_LOWPWR));

    // Polarity pair moved as one unit from shadow to active
    typedef struct packed {
        logic act_high;
        logic idle_high;
    } polarity_t;

endpackage

// File: rtl/pwm_atomic_regs.sv
`timescale 1ns/1ps
module pwm_atomic_regs
    import pwm_atomic_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [3:0]    addr,
    input  logic [W-1:0]  wdata,
    input  logic [W-1:0]  cnt_live,
    output logic [W-1:0]  rdata,
    output logic [W-1:0]  shd_period,
    output logic [W-1:0]  shd_duty,
    output polarity_t     shd_pol,
    output logic          enable,
    output logic          lock,
    output logic          pend_set
);

    localparam logic [W-1:0] KEEP_W = W'(CTRL_KEEP);

    word_sel_e    sel;
    logic         hit;
    logic [W-1:0] ctrl_q;

    assign sel = word_sel_e'(addr[3:2]);
    assign hit = wr_en && (addr[1:0] == 2'b00);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_period <= '0;
            shd_duty   <= '0;
            ctrl_q     <= '0;
        end else if (hit) begin
            unique case (sel)
                SEL_PERIOD: shd_period <= wdata;
                SEL_DUTY:   shd_duty   <= wdata;
                SEL_CTRL:   ctrl_q     <= wdata & KEEP_W;
                SEL_COUNT:  ; // count is read-only
            endcase
        end
    end

    always_comb begin
        unique case (sel)
            SEL_COUNT:  rdata = cnt_live;
            SEL_PERIOD: rdata = shd_period;
            SEL_DUTY:   rdata = shd_duty;
            SEL_CTRL:   rdata = ctrl_q;
        endcase
    end

    assign pend_set          = hit && (sel != SEL_COUNT);
    assign enable            = ctrl_q[CB_ENABLE];
    assign lock              = ctrl_q[CB_LOCK];
    assign shd_pol.act_high  = ctrl_q[CB_ACT_HIGH];
    assign shd_pol.idle_high = ctrl_q[CB_IDLE_HI];

    AST_CTRL_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q & ~KEEP_W) == '0); // R9

    AST_COUNT_WRITE_NO_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 4'h0) |=> ($stable(shd_period) && $stable(shd_duty) && $stable(ctrl_q))); // R2

endmodule

// File: rtl/pwm_atomic_commit.sv
`timescale 1ns/1ps
module pwm_atomic_commit
    import pwm_atomic_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pend_set,
    input  logic lock,
    input  logic boundary,
    output logic commit
);

    commit_st_e state_q, state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (pend_set) state_d = ST_ARMED;                 // stage
            end
            ST_ARMED: begin
                if (lock)          state_d = ST_HELD;              // freeze
                else if (boundary) state_d = pend_set ? ST_ARMED   // apply, restage
                                                      : ST_IDLE;   // apply
            end
            ST_HELD: begin
                if (!lock) state_d = ST_ARMED;                    // release
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        commit = 1'b0;
        unique case (state_q)
            ST_ARMED: commit = boundary && !lock;
            ST_IDLE,
            ST_HELD:  commit = 1'b0;
            default:  commit = 1'b0;
        endcase
    end

    AST_HELD_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HELD && lock) |=> (state_q == ST_HELD)); // R3

    AST_NO_STATE_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_set) |=> (state_q != ST_IDLE)); // R5

endmodule

// File: rtl/pwm_atomic_wave.sv
`timescale 1ns/1ps
module pwm_atomic_wave
    import pwm_atomic_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          commit,
    input  logic [W-1:0]  shd_period,
    input  logic [W-1:0]  shd_duty,
    input  polarity_t     shd_pol,
    output logic [W-1:0]  count,
    output logic [W-1:0]  per_act,
    output logic [W-1:0]  duty_act,
    output polarity_t     pol_act,
    output logic          boundary,
    output logic          pwm_out
);

    localparam logic [W-1:0] ONE = W'(1);

    logic last_count;
    logic running;

    assign running    = enable && (per_act != '0);
    assign last_count = (count == per_act - ONE);
    assign boundary   = !running || last_count;

    // Active configuration, loaded only on commit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_act  <= '0;
            duty_act <= '0;
            pol_act  <= '0;
        end else if (commit) begin
            per_act  <= shd_period;
            duty_act <= shd_duty;
            pol_act  <= shd_pol;
        end
    end

    // Free-running up-counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                      count <= '0;
        else if (!running || last_count) count <= '0;
        else                             count <= count + ONE;
    end

    // Left-aligned decode from registered state
    always_comb begin
        if (running && (count < duty_act)) pwm_out = pol_act.act_high;
        else                               pwm_out = pol_act.idle_high;
    end

    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (running && last_count) |=> (count == '0)); // R2

endmodule

// File: rtl/pwm_atomic.sv
`timescale 1ns/1ps
module pwm_atomic
    import pwm_atomic_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [3:0]    addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  rdata,
    output logic          pwm_out
);

    logic [W-1:0] shd_period, shd_duty, count, per_act, duty_act;
    polarity_t    shd_pol, pol_act;
    logic         enable, lock, pend_set, boundary, commit;

    pwm_atomic_regs #(.W(W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .cnt_live   (count),
        .rdata      (rdata),
        .shd_period (shd_period),
        .shd_duty   (shd_duty),
        .shd_pol    (shd_pol),
        .enable     (enable),
        .lock       (lock),
        .pend_set   (pend_set)
    );

    pwm_atomic_commit u_commit (
        .clk      (clk),
        .rst_n    (rst_n),
        .pend_set (pend_set),
        .lock     (lock),
        .boundary (boundary),
        .commit   (commit)
    );

    pwm_atomic_wave #(.W(W)) u_wave (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .commit     (commit),
        .shd_period (shd_period),
        .shd_duty   (shd_duty),
        .shd_pol    (shd_pol),
        .count      (count),
        .per_act    (per_act),
        .duty_act   (duty_act),
        .pol_act    (pol_act),
        .boundary   (boundary),
        .pwm_out    (pwm_out)
    );

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (per_act != '0) |-> (count < per_act)); // R2

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> ($stable(per_act) && $stable(duty_act) && $stable(pol_act))); // R3

    AST_CHANGE_AT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        (per_act != $past(per_act) || duty_act != $past(duty_act) || pol_act != $past(pol_act))
            |-> $past(boundary)); // R5

    AST_FULL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && per_act != '0 && duty_act >= per_act) |-> (pwm_out == pol_act.act_high)); // R7

    AST_OFF_COUNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (count == '0)); // R8

endmodule

// File: tb/tb_pwm_atomic.sv
`timescale 1ns/1ps
module tb_pwm_atomic;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  addr = 4'h0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        pwm_out;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    pwm_atomic dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 4'h0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] v);
        @(negedge clk);
        addr = a;
        #1 v = rdata;
        addr = 4'h0;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic measure(input int n, output int highs);
        highs = 0;
        for (int i = 0; i < n; i++) begin
            if (pwm_out) highs++;
            @(negedge clk);
        end
    endtask

    // Returns on the falling edge at which the live count reads target
    task automatic poll_count(input logic [31:0] target);
        for (int i = 0; i < 1000; i++) begin
            @(negedge clk);
            if (rdata == target) return;
        end
        check(1'b0, "poll", rdata, target);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        @(negedge clk);
        check(pwm_out == 1'b0, "R1 output", pwm_out, 0);
        check(rdata == 0, "R1 count", rdata, 0);
        rd(4'h4, v); check(v == 0, "R1 period", v, 0);
        rd(4'hC, v); check(v == 0, "R1 ctrl", v, 0);
    endtask

    task automatic t_basic();
        int h; logic [31:0] c1, c2, v;
        wr(4'h4, 10); wr(4'h8, 3); wr(4'hC, 32'h09);
        wait_cyc(25);
        measure(100, h); check(h == 30, "R6 duty 3/10 active high", h, 30);
        @(negedge clk); c1 = rdata;
        @(negedge clk); c2 = rdata;
        check(c2 == (c1 + 1) % 10, "R2 count steps", c2, (c1 + 1) % 10);
        wr(4'h0, 32'h55);
        @(negedge clk); check(rdata < 10, "R2 count write ignored", rdata, 9);
        rd(4'h4, v); check(v == 10, "R2 period readback", v, 10);
    endtask

    task automatic t_lock();
        int h; logic [31:0] v;
        wr(4'hC, 32'h49);
        wr(4'h4, 20); wr(4'h8, 15);
        wait_cyc(20);
        measure(100, h); check(h == 30, "R3 output frozen", h, 30);
        rd(4'h4, v); check(v == 20, "R3 period shadow", v, 20);
        rd(4'h8, v); check(v == 15, "R3 duty shadow", v, 15);
        rd(4'hC, v); check(v == 32'h49, "R9 ctrl readback", v, 32'h49);
        poll_count(1);
        wr(4'hC, 32'h11); // unlock, active low, idle high
        measure(7, h); check(h == 0, "R4 old config to period end", h, 0);
        measure(20, h); check(h == 5, "R4 new config together", h, 5);
    endtask

    task automatic t_midperiod();
        int h;
        wr(4'h4, 10); wr(4'h8, 5); wr(4'hC, 32'h09);
        wait_cyc(50);
        measure(100, h); check(h == 50, "R6 duty 5/10", h, 50);
        poll_count(1);
        wr(4'h8, 2);
        measure(7, h); check(h == 2, "R5 old duty until boundary", h, 2);
        measure(10, h); check(h == 2, "R5 new duty next period", h, 2);
    endtask

    task automatic t_limits();
        int h;
        wr(4'h8, 0);   wait_cyc(30); measure(50, h); check(h == 0,  "R7 duty zero idle", h, 0);
        wr(4'h8, 10);  wait_cyc(30); measure(50, h); check(h == 50, "R7 duty equal period", h, 50);
        wr(4'h8, 200); wait_cyc(30); measure(50, h); check(h == 50, "R7 duty above period", h, 50);
        wr(4'hC, 32'h11); wait_cyc(30); measure(50, h); check(h == 0, "R6 inverted full active", h, 0);
        wr(4'h4, 0);   wait_cyc(30); measure(50, h); check(h == 50, "R7 period zero idle", h, 50);
        @(negedge clk); check(rdata == 0, "R7 count held", rdata, 0);
    endtask

    task automatic t_disable();
        wr(4'h4, 10); wr(4'h8, 4); wr(4'hC, 32'h10);
        wait_cyc(5);
        check(pwm_out == 1'b1, "R8 idle high when off", pwm_out, 1);
        check(rdata == 0, "R8 count held when off", rdata, 0);
        wr(4'hC, 32'h00);
        wait_cyc(5);
        check(pwm_out == 1'b0, "R8 idle low when off", pwm_out, 0);
    endtask

    task automatic t_ctrl_mask();
        logic [31:0] v;
        wr(4'hC, 32'hFFFF_FFFF);
        rd(4'hC, v); check(v == 32'h179, "R9 ctrl mask", v, 32'h179);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        t_reset();
        t_basic();
        t_lock();
        t_midperiod();
        t_limits();
        t_disable();
        t_ctrl_mask();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule